// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers the per-channel completion and fault pulses of a four-channel DMA engine and turns them into sticky flags. Software sees these flags through a small register window. Each channel has two flags: transfer-done and error. Both flags latch whenever the controller and the channel are enabled, whether or not interrupts are enabled for that channel. This lets a driver poll for completion without taking an interrupt.

Two per-channel interrupt-enable bits select which latched flags appear in the masked status view. A single interrupt output is raised while any masked flag is set. Software acknowledges a flag by writing a one to the matching bit of the clear register. The block also holds the controller enable and a per-channel enable and report bit, because these decide whether an incoming event is accepted at all.

The register window is a single-cycle write strobe with a combinational read port. Byte addresses are `0x00` controller enable, `0x04` raw status, `0x08` masked status, `0x0C` clear, `0x10` enabled-channels report, and `0x20 + 4*n` the configuration word of channel n.

Top module: `dma_irq_aggregator`

## Requirements
- R1: After reset, every readable register returns zero and `irq` is low.
- R2: Writing 1 to bit 0 of address `0x00` enables the controller, and writing 0 disables it. Bit 0 reads back the current state and the other bits read zero.
- R3: A `done_evt[n]` or `err_evt[n]` pulse is latched only while the controller is enabled and bit 0 of channel n's configuration word is set. Otherwise it is ignored and raw status is unchanged.
- R4: Latching of raw flags does not depend on the interrupt-enable bits. A flag latched with both enables off shows in raw status, stays out of masked status and leaves `irq` low.
- R5: Masked status (`0x08`) holds raw done bit n in bit n when configuration bit 13 of channel n is set. It holds raw error bit n in bit 16+n when configuration bit 12 of channel n is set.
- R6: Writing to `0x0C` clears raw done bit n where the write data has bit n set, and raw error bit n where the write data has bit 8+n set. Zero bits leave flags untouched, and `0x0C` reads zero.
- R7: When an event and a clear for the same flag fall in the same cycle, the flag is set after that cycle.
- R8: `irq` is high exactly when masked status is non-zero.
- R9: Bit n of the enabled-channels report (`0x10`) is set while the controller is enabled and channel n's enable bit is set. All other bits read zero.
- R10: Raw status holds done flags in bits 7:0 and error flags in bits 15:8. Bits for channels that do not exist, and bits 31:16, read zero. Clear-register bits for channels that do not exist have no effect.
- R11: A channel configuration word keeps only bits 0, 12 and 13. All other bits read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| done_evt | input | NCH | Per-channel transfer-complete pulses |
| err_evt | input | NCH | Per-channel error pulses |
| wr_en | input | 1 | Register write strobe |
| addr | input | AW | Register byte address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data (combinational from `addr`) |
| irq | output | 1 | Combined interrupt request |

## Verification
The embedded properties check on every cycle that accepted events always set their flag, including against a simultaneous clear, and that a clear without an event drops the flag. They also check that no flag rises while its channel is inactive, that padding bits of the raw and masked views stay zero, and that `irq` agrees with the masked view whenever it is addressed. The bench scenarios show what the properties cannot: how the separate interrupt enables of each channel route particular flags into the masked view, the exact readback of each register after resets and writes, and the enabled-channels report as the controller and channel enables change.

// File: rtl/dma_irq_aggregator.sv
module dma_irq_aggregator #(
  parameter int NCH = 4,
  parameter int AW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] done_evt,
  input  logic [NCH-1:0] err_evt,
  input  logic           wr_en,
  input  logic [AW-1:0]  addr,
  input  logic [31:0]    wdata,
  output logic [31:0]    rdata,
  output logic           irq
);
  localparam logic [AW-1:0] A_CTRL = AW'(8'h00);
  localparam logic [AW-1:0] A_RAW  = AW'(8'h04);
  localparam logic [AW-1:0] A_MASK = AW'(8'h08);
  localparam logic [AW-1:0] A_CLR  = AW'(8'h0C);
  localparam logic [AW-1:0] A_ENCH = AW'(8'h10);
  localparam int            A_CFG  = 32;
  localparam logic [31:0]   CHMASK    = (32'd1 << NCH) - 32'd1;
  localparam logic [31:0]   RAW_VALID = CHMASK | (CHMASK << 8);
  localparam logic [31:0]   MSK_VALID = CHMASK | (CHMASK << 16);

  logic           ctrl_en;
  logic [NCH-1:0] ch_en, done_ie, err_ie;
  logic [NCH-1:0] raw_done, raw_err;
  logic [NCH-1:0] active, ev_done, ev_err, clr_done, clr_err;
  logic [NCH-1:0] msk_done, msk_err;
  logic [31:0]    raw_word, msk_word, ench_word;
  logic [31:0]    cfg_word [NCH];

  wire wr_ctrl = wr_en && (addr == A_CTRL);
  wire wr_clr  = wr_en && (addr == A_CLR);

  assign active   = {NCH{ctrl_en}} & ch_en;
  assign ev_done  = done_evt & active;
  assign ev_err   = err_evt & active;
  assign clr_done = wr_clr ? wdata[NCH-1:0]  : '0;
  assign clr_err  = wr_clr ? wdata[8 +: NCH] : '0;
  assign msk_done = raw_done & done_ie;
  assign msk_err  = raw_err & err_ie;
  assign irq      = |{msk_done, msk_err};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctrl_en <= 1'b0;
    else if (wr_ctrl) ctrl_en <= wdata[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      raw_done <= '0;
      raw_err  <= '0;
    end else begin
      raw_done <= (raw_done & ~clr_done) | ev_done;
      raw_err  <= (raw_err & ~clr_err) | ev_err;
    end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wire wr_cfg = wr_en && (addr == AW'(A_CFG + 4 * i));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        ch_en[i]   <= 1'b0;
        err_ie[i]  <= 1'b0;
        done_ie[i] <= 1'b0;
      end else if (wr_cfg) begin
        ch_en[i]   <= wdata[0];
        err_ie[i]  <= wdata[12];
        done_ie[i] <= wdata[13];
      end

    always_comb begin
      cfg_word[i]     = '0;
      cfg_word[i][0]  = ch_en[i];
      cfg_word[i][12] = err_ie[i];
      cfg_word[i][13] = done_ie[i];
    end

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ev_done[i] || ev_err[i]) |-> (raw_done[i] || !$past(ev_done[i])) && (raw_err[i] || !$past(ev_err[i])));

    // R6
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(clr_done[i] && !ev_done[i]) |-> !raw_done[i]);

    // R3
    gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(active[i]) |-> !$rose(raw_done[i]) && !$rose(raw_err[i]));
  end

  always_comb begin
    raw_word = '0;
    raw_word[NCH-1:0]  = raw_done;
    raw_word[8 +: NCH] = raw_err;
    msk_word = '0;
    msk_word[NCH-1:0]   = msk_done;
    msk_word[16 +: NCH] = msk_err;
    ench_word = '0;
    ench_word[NCH-1:0] = active;
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL:  rdata = {31'd0, ctrl_en};
      A_RAW:   rdata = raw_word;
      A_MASK:  rdata = msk_word;
      A_ENCH:  rdata = ench_word;
      default: ;
    endcase
    for (int i = 0; i < NCH; i++)
      if (addr == AW'(A_CFG + 4 * i)) rdata = cfg_word[i];
  end

  // R8
  irq_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_MASK) |-> (irq == (rdata != 32'd0)));

  // R10
  raw_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_RAW) |-> ((rdata & ~RAW_VALID) == 32'd0));

  // R5
  msk_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_MASK) |-> ((rdata & ~MSK_VALID) == 32'd0));

  // R9
  ench_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == A_ENCH && !ctrl_en) |-> (rdata == 32'd0));
endmodule

// File: tb/sim_dma_irq_aggregator.sv
module sim_dma_irq_aggregator;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  done_evt = '0, err_evt = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  dma_irq_aggregator #(.NCH(4), .AW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .done_evt(done_evt), .err_evt(err_evt),
    .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  // {done_evt, err_evt, clear word, expected raw, expected masked}
  localparam logic [63:0] VEC [0:5] = '{
    {4'h1, 4'h0, 16'h0000, 16'h0001, 24'h000001},
    {4'h4, 4'h2, 16'h0000, 16'h0205, 24'h020005},
    {4'h0, 4'h0, 16'h0004, 16'h0201, 24'h020001},
    {4'h1, 4'h0, 16'h0001, 16'h0201, 24'h020001},
    {4'h8, 4'h9, 16'h0201, 16'h0908, 24'h010000},
    {4'h0, 4'h0, 16'hFFFF, 16'h0000, 24'h000000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input string req, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1 chk(req, rdata, exp);
  endtask

  task automatic step(input logic [3:0] d, input logic [3:0] e, input logic w,
                      input logic [7:0] a, input logic [31:0] v);
    @(negedge clk);
    done_evt = d; err_evt = e; wr_en = w; addr = a; wdata = v;
    @(negedge clk);
    done_evt = '0; err_evt = '0; wr_en = 1'b0; wdata = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] v);
    step(4'h0, 4'h0, 1'b1, a, v);
  endtask

  initial begin
    #(8 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(8'h00, "R1 ctrl", 0);
    rd(8'h04, "R1 raw", 0);
    rd(8'h08, "R1 masked", 0);
    rd(8'h10, "R1 enabled", 0);
    rd(8'h20, "R1 cfg0", 0);
    chk("R1 irq", {31'd0, irq}, 0);

    // R3: controller off ignores events
    for (int i = 0; i < 4; i++) wr(8'h20 + 8'(4 * i), 32'h1);
    step(4'hF, 4'hF, 1'b0, 8'h00, 0);
    rd(8'h04, "R3 ctrl off raw", 0);

    // R2 / R9
    wr(8'h00, 32'hFFFF_FFFF);
    rd(8'h00, "R2 ctrl on", 1);
    rd(8'h10, "R9 all enabled", 32'hF);
    wr(8'h28, 32'h0);
    rd(8'h10, "R9 ch2 off", 32'hB);
    step(4'h4, 4'h4, 1'b0, 8'h00, 0);
    rd(8'h04, "R3 channel off raw", 0);
    wr(8'h28, 32'h1);

    // R4: latch with enables off
    step(4'h2, 4'h0, 1'b0, 8'h00, 0);
    rd(8'h04, "R4 raw", 32'h2);
    rd(8'h08, "R4 masked", 0);
    chk("R4 irq", {31'd0, irq}, 0);

    // R11 config readback
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, "R11 cfg0", 32'h3001);
    wr(8'h24, 32'h1001);
    wr(8'h28, 32'h2001);
    wr(8'h2C, 32'h0001);
    rd(8'h24, "R11 cfg1", 32'h1001);

    // R6 / R10: zero and phantom clear bits have no effect
    wr(8'h0C, 32'hFFFF_F0F0);
    rd(8'h04, "R10 phantom clear", 32'h2);
    rd(8'h0C, "R6 clear reads zero", 0);
    wr(8'h0C, 32'h0000_FFFF);
    rd(8'h04, "R6 clear all", 0);

    // Table: R5 R6 R7 R8 R10
    for (int k = 0; k < 6; k++) begin
      logic [63:0] v;
      v = VEC[k];
      step(v[63:60], v[59:56], v[55:40] != 16'h0, 8'h0C, {16'h0, v[55:40]});
      rd(8'h04, "R7 R6 raw vector", {16'h0, v[39:24]});
      rd(8'h08, "R5 masked vector", {8'h0, v[23:0]});
      chk("R8 irq vector", {31'd0, irq}, {31'd0, v[23:0] != 24'h0});
    end

    // R8: error only through its enable
    step(4'h0, 4'h2, 1'b0, 8'h00, 0);
    rd(8'h08, "R5 err ch1", 32'h0002_0000);
    chk("R8 irq err", {31'd0, irq}, 1);
    wr(8'h0C, 32'h0000_0200);
    chk("R8 irq cleared", {31'd0, irq}, 0);

    // R2 disable
    wr(8'h00, 32'h0);
    rd(8'h00, "R2 ctrl off", 0);
    rd(8'h10, "R9 ctrl off", 0);
    step(4'hF, 4'hF, 1'b0, 8'h00, 0);
    rd(8'h04, "R3 disabled again", 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule